// File: doc/BRIEF.md
# Shared-Memory Per-Link Transmit Cell Queue

This block holds outgoing 53-byte cells for up to sixteen transmit links in one shared cell memory. Software-visible configuration gives each link a queue length of zero to fifteen cells. The block carves the memory into consecutive partitions, one per link. Each partition starts at the slot equal to the sum of the lengths of every lower-numbered link. One further slot is set aside for a fixed filler cell. That cell is never written, and the block hands it out whenever a link asks for a cell while its queue is empty.

Cells enter one byte per clock on a valid/ready stream. The first byte is flagged as start-of-cell and carries the destination link number. The whole cell is written into that link's partition when its last byte is accepted. A link is served by presenting its number on a request handshake. The block then streams one complete cell back on a valid/ready output, taken either from the head of the queue or from the filler slot. An optional filter drops incoming filler and unassigned cells before they reach any queue.

Back-pressure rules: `in_ready` and `req_ready` are both low in any cycle where `cfg_apply` is high. `req_ready` also stays low while a cell is being emitted. `out_data` holds its byte for as long as `out_valid` is high and `out_ready` is low. No input byte is ever refused for lack of space: a cell that does not fit is accepted on the stream and then discarded whole.

Top module: `cellq_shared_buffer`

## Requirements
- R1: A cell is 53 bytes. Its first byte is marked by `in_sop` together with `in_link`. Cells written to a link come back from that link byte for byte, in arrival order. On the output, `out_sop` marks byte 0 and `out_eop` marks byte 52.
- R2: Partitions do not overlap. Cells queued on one link never appear on another, and the order in which links are served does not change any link's contents.
- R3: A cell that arrives for a link whose queue is full, or whose length is zero, is dropped whole and the queue keeps its contents. The link's bit in `stat_ovf` is then set and stays set until that link is flushed.
- R4: When `cfg_apply` carries lengths whose total exceeds 118, the new lengths are not used and `cfg_bad` pulses high for one cycle after that edge. The previous lengths stay in effect. A total of exactly 118 is accepted. Each link's length occupies bits [4*i+3:4*i] of `cfg_lens`.
- R5: An accepted configuration flushes every link whose length or partition base changes: its queue is emptied and its overflow flag is cleared. Other links keep their cells and flags.
- R6: While `drop_en` is high, an incoming cell is discarded without any flag if header bytes 0 to 2 are zero, the upper nibble of byte 3 is zero, and either byte 3 equals 01h (filler) or bit 0 of byte 3 is 0 (unassigned). Header 00 00 00 05h is kept. While `drop_en` is low, every cell is queued.
- R7: A request for a link with an empty queue returns the filler cell and raises `out_idle` for that cell. The filler cell is bytes 00 00 00 01h, then 52h, then 48 bytes of 6Ah.
- R8: `stat_count` gives each link's fill level in 4 bits per link. `stat_empty` is high when the level is 0. `stat_full` is high when the level equals the link's length, so a zero-length link shows both empty and full.
- R9: `in_ready` and `req_ready` are low whenever `cfg_apply` is high. `req_ready` is low while `out_valid` is high. A stalled output holds `out_valid` and `out_data` steady.
- R10: The read and write positions of each link wrap within that link's own partition. Pushing and popping more cells than the length, in interleaved order, still returns them in order and lets the level reach the full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; all lengths zero afterwards |
| drop_en | input | 1 | Enable discard of filler and unassigned cells |
| cfg_apply | input | 1 | One-cycle strobe to load `cfg_lens` |
| cfg_lens | input | 64 | Per-link queue lengths, 4 bits per link |
| cfg_bad | output | 1 | Pulses when a configuration is refused |
| in_valid | input | 1 | Ingress byte valid |
| in_ready | output | 1 | Ingress byte accepted |
| in_sop | input | 1 | First byte of a cell |
| in_link | input | 4 | Destination link, sampled with `in_sop` |
| in_data | input | 8 | Ingress byte |
| req_valid | input | 1 | Cell request valid |
| req_ready | output | 1 | Cell request accepted |
| req_link | input | 4 | Link being served |
| out_valid | output | 1 | Egress byte valid |
| out_ready | input | 1 | Egress byte taken |
| out_sop | output | 1 | Egress byte 0 |
| out_eop | output | 1 | Egress byte 52 |
| out_idle | output | 1 | Cell being emitted is the filler cell |
| out_data | output | 8 | Egress byte |
| stat_empty | output | 16 | Per-link queue empty |
| stat_full | output | 16 | Per-link queue at its length |
| stat_ovf | output | 16 | Per-link sticky overflow flag |
| stat_count | output | 64 | Per-link fill level, 4 bits per link |

## Verification
The bench uses the default parameters: sixteen links, 118 data slots plus the filler slot, and at most fifteen cells per link. With these values, a total of 120 cells (eight links at fifteen) crosses the limit, and a total of 7×15+13 lands exactly on it, so both sides of the capacity check are reachable. Short partitions of one to four cells make full, overflow and pointer wrap quick to reach. Changing one link's length moves the partition bases of the links above it, which exercises selective flushing.

// File: rtl/cellq_pkg.sv
package cellq_pkg;
  localparam int BYTE_W     = 8;
  localparam int CELL_BYTES = 53;
  localparam int CELL_W     = CELL_BYTES * BYTE_W;
  localparam int BC_W       = $clog2(CELL_BYTES);
  localparam logic [7:0] IDLE_HEC  = 8'h52;
  localparam logic [7:0] IDLE_FILL = 8'h6A;

  // Header test for cells that carry no traffic (filler or unassigned).
  function automatic logic is_filler(input logic [31:0] hdr);
    return (hdr[31:4] == 28'd0) && (hdr[0] == 1'b0 || hdr[3:0] == 4'h1);
  endfunction

  function automatic logic [CELL_W-1:0] idle_cell();
    logic [CELL_W-1:0] c;
    for (int i = 0; i < CELL_BYTES; i++) begin
      if (i < 3)       c[CELL_W-1-BYTE_W*i -: BYTE_W] = 8'h00;
      else if (i == 3) c[CELL_W-1-BYTE_W*i -: BYTE_W] = 8'h01;
      else if (i == 4) c[CELL_W-1-BYTE_W*i -: BYTE_W] = IDLE_HEC;
      else             c[CELL_W-1-BYTE_W*i -: BYTE_W] = IDLE_FILL;
    end
    return c;
  endfunction
endpackage

// File: rtl/cellq_partition.sv
module cellq_partition #(
  parameter int NUM_LINKS  = 16,
  parameter int LEN_W      = 4,
  parameter int SLOT_W     = 7,
  parameter int DATA_SLOTS = 118
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_apply,
  input  logic [NUM_LINKS*LEN_W-1:0] cfg_lens,
  output logic [LEN_W-1:0]           len_q  [NUM_LINKS],
  output logic [SLOT_W-1:0]          base_q [NUM_LINKS],
  output logic [NUM_LINKS-1:0]       flush,
  output logic                       cfg_bad
);
  localparam int SUM_W = $clog2(NUM_LINKS * ((1 << LEN_W) - 1) + 1) + 1;

  logic [SUM_W-1:0]  new_base [NUM_LINKS];
  logic [SUM_W-1:0]  new_total;
  logic              fits;

  always_comb begin
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      new_base[i] = acc;
      acc = acc + SUM_W'(cfg_lens[i*LEN_W +: LEN_W]);
    end
    new_total = acc;
  end

  assign fits = (new_total <= SUM_W'(DATA_SLOTS));

  always_comb begin
    for (int i = 0; i < NUM_LINKS; i++) begin
      flush[i] = cfg_apply && fits &&
                 ((cfg_lens[i*LEN_W +: LEN_W] != len_q[i]) ||
                  (new_base[i][SLOT_W-1:0] != base_q[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_bad <= 1'b0;
      for (int i = 0; i < NUM_LINKS; i++) begin
        len_q[i]  <= '0;
        base_q[i] <= '0;
      end
    end else begin
      cfg_bad <= cfg_apply && !fits;
      if (cfg_apply && fits) begin
        for (int i = 0; i < NUM_LINKS; i++) begin
          len_q[i]  <= cfg_lens[i*LEN_W +: LEN_W];
          base_q[i] <= new_base[i][SLOT_W-1:0];
        end
      end
    end
  end

  // Total of the lengths in force, recomputed from the held state.
  logic [SUM_W-1:0] live_total;
  always_comb begin
    live_total = '0;
    for (int i = 0; i < NUM_LINKS; i++) live_total = live_total + SUM_W'(len_q[i]);
  end

  assert_total_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live_total <= SUM_W'(DATA_SLOTS));
  assert_refused_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_apply && !fits |=> $stable(len_q[0]) && $stable(base_q[NUM_LINKS-1]));
endmodule

// File: rtl/cellq_link_state.sv
module cellq_link_state #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [LEN_W-1:0] len,
  input  logic             push,
  input  logic             pop,
  input  logic             ovf_set,
  output logic [LEN_W-1:0] count,
  output logic [LEN_W-1:0] wptr,
  output logic [LEN_W-1:0] rptr,
  output logic             ovf
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      count <= '0;
      wptr  <= '0;
      rptr  <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= count + (push ? ONE : '0) - (pop ? ONE : '0);
      if (push) wptr <= (wptr == len - ONE) ? '0 : wptr + ONE;
      if (pop)  rptr <= (rptr == len - ONE) ? '0 : rptr + ONE;
      if (ovf_set) ovf <= 1'b1;
    end
  end

  assert_count_within_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= len);
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0 && !ovf);
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !flush |=> ovf);
  assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
  assert_wrap_inside_R10: assert property (@(posedge clk) disable iff (!rst_n)
    len != '0 |-> wptr < len && rptr < len);
endmodule

// File: rtl/cellq_store.sv
module cellq_store #(
  parameter int DEPTH  = 118,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 424
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  assert_write_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> waddr < ADDR_W'(DEPTH));
endmodule

// File: rtl/cellq_shared_buffer.sv
module cellq_shared_buffer
  import cellq_pkg::*;
#(
  parameter int NUM_LINKS   = 16,
  parameter int TOTAL_SLOTS = 119,
  parameter int MAX_LEN     = 15,
  localparam int LINK_W     = $clog2(NUM_LINKS),
  localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       drop_en,
  input  logic                       cfg_apply,
  input  logic [NUM_LINKS*LEN_W-1:0] cfg_lens,
  output logic                       cfg_bad,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_sop,
  input  logic [LINK_W-1:0]          in_link,
  input  logic [7:0]                 in_data,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [LINK_W-1:0]          req_link,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic                       out_sop,
  output logic                       out_eop,
  output logic                       out_idle,
  output logic [7:0]                 out_data,
  output logic [NUM_LINKS-1:0]       stat_empty,
  output logic [NUM_LINKS-1:0]       stat_full,
  output logic [NUM_LINKS-1:0]       stat_ovf,
  output logic [NUM_LINKS*LEN_W-1:0] stat_count
);
  localparam int DATA_SLOTS = TOTAL_SLOTS - 1;  // one slot kept for the filler cell
  localparam int SLOT_W     = $clog2(DATA_SLOTS);

  logic [LEN_W-1:0]     len_a  [NUM_LINKS];
  logic [SLOT_W-1:0]    base_a [NUM_LINKS];
  logic [LEN_W-1:0]     cnt_a  [NUM_LINKS];
  logic [LEN_W-1:0]     wp_a   [NUM_LINKS];
  logic [LEN_W-1:0]     rp_a   [NUM_LINKS];
  logic [NUM_LINKS-1:0] flush_m;

  cellq_partition #(.NUM_LINKS(NUM_LINKS), .LEN_W(LEN_W), .SLOT_W(SLOT_W),
                    .DATA_SLOTS(DATA_SLOTS)) u_part (
    .clk(clk), .rst_n(rst_n), .cfg_apply(cfg_apply), .cfg_lens(cfg_lens),
    .len_q(len_a), .base_q(base_a), .flush(flush_m), .cfg_bad(cfg_bad));

  // ---------------- ingress assembly ----------------
  logic              in_fire, start, cont, last;
  logic              in_cell;
  logic [LINK_W-1:0] cur_link;
  logic [BC_W-1:0]   bcnt;
  logic [CELL_W-1:0] asm_q, asm_next;
  logic              filtered, room, wr_en, ovf_hit;

  assign in_ready = !cfg_apply;
  assign in_fire  = in_valid && in_ready;
  assign start    = in_fire && in_sop;
  assign cont     = in_fire && !in_sop && in_cell;
  assign last     = cont && (bcnt == BC_W'(CELL_BYTES - 1));
  assign asm_next = {asm_q[CELL_W-BYTE_W-1:0], in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cell  <= 1'b0;
      bcnt     <= '0;
      cur_link <= '0;
      asm_q    <= '0;
    end else if (start) begin
      in_cell  <= 1'b1;
      bcnt     <= BC_W'(1);
      cur_link <= in_link;
      asm_q    <= asm_next;
    end else if (cont) begin
      asm_q <= asm_next;
      if (last) begin
        in_cell <= 1'b0;
        bcnt    <= '0;
      end else begin
        bcnt <= bcnt + BC_W'(1);
      end
    end
  end

  assign filtered = drop_en && is_filler(asm_next[CELL_W-1 -: 32]);
  assign room     = (len_a[cur_link] != '0) && (cnt_a[cur_link] != len_a[cur_link]);
  assign wr_en    = last && !filtered && room;
  assign ovf_hit  = last && !filtered && !room;

  // ---------------- shared memory ----------------
  logic              req_fire, rd_hit;
  logic [CELL_W-1:0] rd_cell;

  cellq_store #(.DEPTH(DATA_SLOTS), .ADDR_W(SLOT_W), .DATA_W(CELL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en),
    .waddr(base_a[cur_link] + SLOT_W'(wp_a[cur_link])), .wdata(asm_next),
    .raddr(base_a[req_link] + SLOT_W'(rp_a[req_link])), .rdata(rd_cell));

  // ---------------- per-link queue state ----------------
  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
    cellq_link_state #(.LEN_W(LEN_W)) u_ls (
      .clk(clk), .rst_n(rst_n), .flush(flush_m[g]), .len(len_a[g]),
      .push(wr_en && cur_link == LINK_W'(g)),
      .pop(rd_hit && req_link == LINK_W'(g)),
      .ovf_set(ovf_hit && cur_link == LINK_W'(g)),
      .count(cnt_a[g]), .wptr(wp_a[g]), .rptr(rp_a[g]), .ovf(stat_ovf[g]));
    assign stat_count[g*LEN_W +: LEN_W] = cnt_a[g];
    assign stat_empty[g] = (cnt_a[g] == '0);
    assign stat_full[g]  = (cnt_a[g] == len_a[g]);
  end

  // ---------------- egress ----------------
  logic              ob_busy, ob_idle;
  logic [BC_W-1:0]   ob_cnt;
  logic [CELL_W-1:0] ob_sh;

  assign req_ready = !ob_busy && !cfg_apply;
  assign req_fire  = req_valid && req_ready;
  assign rd_hit    = req_fire && (cnt_a[req_link] != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_busy <= 1'b0;
      ob_idle <= 1'b0;
      ob_cnt  <= '0;
      ob_sh   <= '0;
    end else if (req_fire) begin
      ob_busy <= 1'b1;
      ob_cnt  <= '0;
      ob_idle <= !rd_hit;
      ob_sh   <= rd_hit ? rd_cell : idle_cell();
    end else if (ob_busy && out_ready) begin
      ob_sh <= {ob_sh[CELL_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
      if (ob_cnt == BC_W'(CELL_BYTES - 1)) ob_busy <= 1'b0;
      else                                 ob_cnt  <= ob_cnt + BC_W'(1);
    end
  end

  assign out_valid = ob_busy;
  assign out_data  = ob_sh[CELL_W-1 -: BYTE_W];
  assign out_sop   = ob_busy && (ob_cnt == '0);
  assign out_eop   = ob_busy && (ob_cnt == BC_W'(CELL_BYTES - 1));
  assign out_idle  = ob_busy && ob_idle;

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop));
  assert_no_req_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);
  assert_idle_on_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && stat_empty[req_link] |=> out_idle && out_sop);
  assert_one_marker_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_sop, out_eop}));
  assert_drop_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit && !flush_m[cur_link] |=> stat_ovf[$past(cur_link)]);
endmodule

// File: tb/cellq_shared_buffer_test.sv
module cellq_shared_buffer_test;
  localparam int NL = 16;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drop_en = 1'b0, cfg_apply = 1'b0;
  logic [NL*LW-1:0] cfg_lens = '0;
  logic cfg_bad;
  logic in_valid = 1'b0, in_sop = 1'b0;
  logic in_ready;
  logic [3:0] in_link = '0;
  logic [7:0] in_data = '0;
  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_link = '0;
  logic out_valid, out_sop, out_eop, out_idle;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic [NL-1:0] stat_empty, stat_full, stat_ovf;
  logic [NL*LW-1:0] stat_count;

  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  cellq_shared_buffer uut (
    .clk(clk), .rst_n(rst_n), .drop_en(drop_en), .cfg_apply(cfg_apply),
    .cfg_lens(cfg_lens), .cfg_bad(cfg_bad), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_link(in_link), .in_data(in_data), .req_valid(req_valid),
    .req_ready(req_ready), .req_link(req_link), .out_valid(out_valid),
    .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop), .out_idle(out_idle),
    .out_data(out_data), .stat_empty(stat_empty), .stat_full(stat_full),
    .stat_ovf(stat_ovf), .stat_count(stat_count));

  task automatic check(input logic ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] cbyte(input logic [31:0] h, input logic [7:0] tag, input int i);
    if (i < 4)  return h[31-8*i -: 8];
    if (i == 4) return 8'hA5;
    return tag + 8'(i);
  endfunction

  function automatic logic [7:0] ibyte(input int i);
    if (i < 3)  return 8'h00;
    if (i == 3) return 8'h01;
    if (i == 4) return 8'h52;
    return 8'h6A;
  endfunction

  function automatic int cnt_of(input int l);
    return int'(stat_count[l*LW +: LW]);
  endfunction

  task automatic send_cell(input int l, input logic [31:0] h, input logic [7:0] tag);
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_link  = 4'(l);
      in_data  = cbyte(h, tag, i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  // Requests one cell and compares it; idle selects the filler cell as expectation.
  task automatic pull_check(input int l, input logic [31:0] h, input logic [7:0] tag,
                            input logic idle, input string rq);
    int bad = 0;
    int first_act = 0, first_exp = 0;
    logic [7:0] e;
    @(negedge clk);
    req_valid = 1'b1;
    req_link  = 4'(l);
    @(negedge clk);
    req_valid = 1'b0;
    check(out_valid && out_sop && (out_idle == idle), rq, int'(out_idle), int'(idle));
    for (int i = 0; i < 53; i++) begin
      e = idle ? ibyte(i) : cbyte(h, tag, i);
      if (out_data !== e || !out_valid || (i == 52 && !out_eop)) begin
        if (bad == 0) begin first_act = int'(out_data); first_exp = int'(e); end
        bad++;
      end
      if (i < 52) @(negedge clk);
    end
    check(bad == 0, rq, first_act, first_exp);
    @(negedge clk);
  endtask

  task automatic apply_cfg(input logic [NL*LW-1:0] v, input logic exp_bad);
    @(negedge clk);
    cfg_lens  = v;
    cfg_apply = 1'b1;
    #1;
    check(!in_ready && !req_ready, "R9 ready low during apply", int'(in_ready), 0);
    @(negedge clk);
    cfg_apply = 1'b0;
    check(cfg_bad == exp_bad, "R4 cfg_bad", int'(cfg_bad), int'(exp_bad));
  endtask

  function automatic logic [NL*LW-1:0] cfg_a();
    logic [NL*LW-1:0] v = '0;
    v[0*LW +: LW] = 4'd2;
    v[1*LW +: LW] = 4'd3;
    v[3*LW +: LW] = 4'd1;
    return v;
  endfunction

  task automatic t_reset();
    check(in_ready && req_ready && !out_valid, "R9 reset ready", int'(out_valid), 0);
    check(stat_empty == '1 && stat_ovf == '0 && stat_count == '0, "R8 reset status",
          int'(stat_ovf), 0);
  endtask

  task automatic t_config_basic();
    apply_cfg(cfg_a(), 1'b0);
    check(stat_empty[5] && stat_full[5], "R8 zero-length empty and full",
          int'(stat_full[5]), 1);
    check(!stat_full[1], "R8 link1 not full", int'(stat_full[1]), 0);
  endtask

  task automatic t_order_wrap();
    send_cell(1, 32'h0010_0020, 8'd10);
    send_cell(1, 32'h0010_0020, 8'd20);
    check(cnt_of(1) == 2, "R8 count after two pushes", cnt_of(1), 2);
    pull_check(1, 32'h0010_0020, 8'd10, 1'b0, "R1 first cell out");
    send_cell(1, 32'h0010_0020, 8'd30);
    send_cell(1, 32'h0010_0020, 8'd40);
    check(cnt_of(1) == 3 && stat_full[1], "R10 full after wrap", cnt_of(1), 3);
    pull_check(1, 32'h0010_0020, 8'd20, 1'b0, "R10 order after wrap a");
    pull_check(1, 32'h0010_0020, 8'd30, 1'b0, "R10 order after wrap b");
    pull_check(1, 32'h0010_0020, 8'd40, 1'b0, "R10 order after wrap c");
    check(stat_empty[1], "R8 empty after drain", int'(stat_empty[1]), 1);
  endtask

  task automatic t_independent();
    send_cell(0, 32'h0123_4560, 8'd50);
    send_cell(3, 32'h0ABC_DEF0, 8'd60);
    pull_check(3, 32'h0ABC_DEF0, 8'd60, 1'b0, "R2 link3 own cell");
    pull_check(0, 32'h0123_4560, 8'd50, 1'b0, "R2 link0 own cell");
  endtask

  task automatic t_overflow();
    send_cell(0, 32'h0000_1000, 8'd70);
    send_cell(0, 32'h0000_1000, 8'd80);
    send_cell(0, 32'h0000_1000, 8'd90);
    check(stat_ovf[0] && cnt_of(0) == 2, "R3 full link drop", cnt_of(0), 2);
    send_cell(5, 32'h0000_1000, 8'd95);
    check(stat_ovf[5] && cnt_of(5) == 0, "R3 zero-length drop", int'(stat_ovf[5]), 1);
    check(!stat_ovf[1] && !stat_ovf[3], "R3 other flags clear", int'(stat_ovf[1]), 0);
    pull_check(0, 32'h0000_1000, 8'd70, 1'b0, "R3 kept cell a");
    pull_check(0, 32'h0000_1000, 8'd80, 1'b0, "R3 kept cell b");
  endtask

  task automatic t_idle();
    pull_check(0, 32'h0, 8'd0, 1'b1, "R7 idle on empty link");
    pull_check(5, 32'h0, 8'd0, 1'b1, "R7 idle on zero-length link");
  endtask

  task automatic t_filter();
    drop_en = 1'b1;
    send_cell(1, 32'h0000_0001, 8'd1);
    send_cell(1, 32'h0000_0000, 8'd2);
    send_cell(1, 32'h0000_0004, 8'd3);
    check(cnt_of(1) == 0 && !stat_ovf[1], "R6 filler dropped", cnt_of(1), 0);
    send_cell(1, 32'h0000_0005, 8'd100);
    check(cnt_of(1) == 1, "R6 CLP=1 kept", cnt_of(1), 1);
    drop_en = 1'b0;
    send_cell(1, 32'h0000_0001, 8'd110);
    check(cnt_of(1) == 2, "R6 filter off queues filler", cnt_of(1), 2);
    pull_check(1, 32'h0000_0005, 8'd100, 1'b0, "R6 kept cell content");
    pull_check(1, 32'h0000_0001, 8'd110, 1'b0, "R6 unfiltered cell content");
  endtask

  task automatic t_hold();
    int bad = 0;
    send_cell(1, 32'h0777_0000, 8'd120);
    @(negedge clk);
    out_ready = 1'b0;
    req_valid = 1'b1;
    req_link  = 4'd1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (!out_valid || out_data !== 8'h07 || req_ready) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R9 stalled output holds", int'(out_data), 7);
    out_ready = 1'b1;
    for (int i = 0; i < 53; i++) begin
      if (out_data !== cbyte(32'h0777_0000, 8'd120, i)) bad++;
      @(negedge clk);
    end
    check(bad == 0 && !out_valid, "R9 cell after stall", bad, 0);
  endtask

  task automatic t_flush();
    logic [NL*LW-1:0] v;
    send_cell(0, 32'h0000_2000, 8'd130);
    send_cell(3, 32'h0000_3000, 8'd140);
    send_cell(1, 32'h0000_4000, 8'd150);
    v = cfg_a();
    v[1*LW +: LW] = 4'd4;
    apply_cfg(v, 1'b0);
    check(cnt_of(0) == 1 && stat_ovf[0], "R5 unchanged link kept", cnt_of(0), 1);
    check(cnt_of(1) == 0 && cnt_of(3) == 0, "R5 moved links flushed", cnt_of(3), 0);
    check(!stat_ovf[5], "R5 moved flag cleared", int'(stat_ovf[5]), 0);
    pull_check(0, 32'h0000_2000, 8'd130, 1'b0, "R5 kept cell content");
  endtask

  task automatic t_reject();
    logic [NL*LW-1:0] v = '0;
    for (int i = 0; i < 8; i++) v[i*LW +: LW] = 4'd15;
    apply_cfg(v, 1'b1);
    send_cell(3, 32'h0000_5000, 8'd160);
    check(cnt_of(3) == 1 && stat_full[3], "R4 old length in force", cnt_of(3), 1);
    v = '0;
    for (int i = 0; i < 7; i++) v[i*LW +: LW] = 4'd15;
    v[7*LW +: LW] = 4'd13;
    apply_cfg(v, 1'b0);
    send_cell(7, 32'h0000_6000, 8'd170);
    check(cnt_of(7) == 1 && !stat_full[7], "R4 exact total accepted", cnt_of(7), 1);
    pull_check(7, 32'h0000_6000, 8'd170, 1'b0, "R2 top partition content");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config_basic();
    t_order_wrap();
    t_independent();
    t_overflow();
    t_idle();
    t_filter();
    t_hold();
    t_flush();
    t_reject();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule